// File: doc/BRIEF.md
# Reloading Prescaler with Event Counter

This block divides a tick enable down by a programmable ratio and counts how many divided periods have elapsed. A down-counting prescale register steps toward zero on each tick. The tick that finds it at zero reloads it from a programmable reload register, and a 32-bit event counter advances on that same tick. With a reload value of N, the event counter therefore advances once every N+1 ticks.

Software can write the reload value, the live prescale count and the event counter at any time, each through its own load strobe sharing one data bus. The live count and the event counter are visible on the outputs. The tick enable is produced elsewhere, nominally at 20 MHz, and address decoding sits outside the block.

Top module: `presc_evcnt`

## Requirements
- R1: Reset sets the reload register, the live count and the event counter to zero.
- R2: On a tick with no count load, a nonzero live count decreases by exactly one and the event counter is unchanged.
- R3: On a tick with no count load, a live count of zero takes the reload register's value. The event counter increases by one on that same tick, unless it is being loaded.
- R4: In a cycle with no tick and no load, the live count and the event counter keep their values.
- R5: With a reload value of zero, the live count stays at zero and the event counter increases on every tick.
- R6: The event counter wraps from 0xFFFFFFFF to 0x00000000.
- R7: A load in the same cycle as a tick wins for the register being loaded. The loaded data appears on the next cycle, and ticking resumes from it.
- R8: Writing the reload register leaves the live count untouched. The new value is first used at the next reload, and a reload on the same cycle as the write still uses the old value.
- R9: A load of one register does not stop a same-cycle tick from acting on the other. A count load on a tick at zero still advances the event counter.
- R10: With reload 5 and a starting count of 7, successive ticks produce counts 6,5,4,3,2,1,0,5,4,3,2,1,0,5. The event counter advances exactly on the two 0-to-5 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler clock enable |
| ld_reload | input | 1 | Load reload register from wr_data |
| ld_count | input | 1 | Load live prescale count from wr_data |
| ld_events | input | 1 | Load event counter from wr_data |
| wr_data | input | 32 | Load data |
| count_o | output | 32 | Live prescale count |
| events_o | output | 32 | Event counter |

## Verification
The bench aims at the reload-one-tick-late timing. A design that reloaded on reaching zero would skip the 0 state, emit 7,6,...,1,5 and count early. Reload zero is exercised because a design that treated it as "divide by one" with an off-by-one would stall the event counter or let the count underflow to all ones. Same-cycle collisions are driven: a load racing a tick, and a reload write at the moment of reload. A design that lets the tick win, or that feeds the fresh reload value straight into the count, shows the wrong value on the next cycle. The event counter is taken across its top value to catch a saturating counter or a missing carry.

// File: rtl/presc_evcnt.sv
module presc_evcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld_reload,
  input  logic         ld_count,
  input  logic         ld_events,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_o,
  output logic [W-1:0] events_o
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] reload_q, count_q, events_q;
  logic         at_zero, wrap_tick;

  assign at_zero   = (count_q == ZERO);
  assign wrap_tick = tick & at_zero;
  assign count_o   = count_q;
  assign events_o  = events_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         reload_q <= ZERO;
    else if (ld_reload) reload_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         count_q <= ZERO;
    else if (ld_count)  count_q <= wr_data;
    else if (wrap_tick) count_q <= reload_q;
    else if (tick)      count_q <= count_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         events_q <= ZERO;
    else if (ld_events) events_q <= wr_data;
    else if (wrap_tick) events_q <= events_q + ONE;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (count_o == ZERO && events_o == ZERO)); // R1

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_count && count_o != ZERO) |=> count_o == $past(count_o) - ONE); // R2

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_count && count_o == ZERO) |=> count_o == $past(reload_q)); // R3

  AST_EVENT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_events && count_o == ZERO) |=> events_o == $past(events_o) + ONE); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_count && !ld_events) |=> ($stable(count_o) && $stable(events_o))); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_count |=> count_o == $past(wr_data)); // R7

  AST_EVENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_events && !(tick && count_o == ZERO)) |=> $stable(events_o)); // R2

endmodule

// File: tb/test_presc_evcnt.sv
module test_presc_evcnt;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, ld_reload = 1'b0, ld_count = 1'b0, ld_events = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count_o, events_o;

  always #4 clk = ~clk;

  presc_evcnt #(.W(W)) i_presc_evcnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_reload(ld_reload),
    .ld_count(ld_count), .ld_events(ld_events), .wr_data(wr_data),
    .count_o(count_o), .events_o(events_o)
  );

  typedef struct {
    logic [W-1:0] c;
    logic [W-1:0] e;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] m_reload = '0, m_count = '0, m_events = '0;
  bit done = 0;

  // Driver: drives one cycle of stimulus, predicts the state after the edge.
  task automatic step(input bit t, input bit lr, input bit lc, input bit le,
                      input logic [W-1:0] d, input string tag);
    exp_t it;
    logic [W-1:0] nc, ne;
    @(negedge clk);
    tick = t; ld_reload = lr; ld_count = lc; ld_events = le; wr_data = d;
    nc = m_count; ne = m_events;
    if (t) begin
      if (m_count == 0) begin nc = m_reload; ne = m_events + 1; end
      else nc = m_count - 1;
    end
    if (lc) nc = d;
    if (le) ne = d;
    if (lr) m_reload = d;
    m_count = nc; m_events = ne;
    it.c = nc; it.e = ne; it.tag = tag;
    exp_q.push_back(it);
    @(posedge clk);
    #2;
    tick = 0; ld_reload = 0; ld_count = 0; ld_events = 0;
  endtask

  // Monitor: compares each prediction just after the edge it belongs to.
  always @(posedge clk) begin
    exp_t it;
    #1;
    if (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      n_checks++;
      if (count_o !== it.c || events_o !== it.e) begin
        n_fail++;
        $display("FAIL %s: count=%h events=%h expected count=%h events=%h",
                 it.tag, count_o, events_o, it.c, it.e);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    n_checks++;
    if (count_o !== '0 || events_o !== '0) begin
      n_fail++;
      $display("FAIL R1: count=%h events=%h expected count=0 events=0", count_o, events_o);
    end
    // R5: reload zero after reset (also shows reload register cleared, R1)
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, '0, "R5");
    // R4: idle cycles
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 32'hDEAD, "R4");
    // R10: reload 5, start count 7, fourteen ticks
    step(0, 1, 0, 0, 32'd5, "R8");
    step(0, 0, 1, 0, 32'd7, "R7");
    step(0, 0, 0, 1, 32'd0, "R7");
    for (int i = 0; i < 14; i++) step(1, 0, 0, 0, '0, "R10");
    if (m_count != 5 || m_events != 2) begin
      n_fail++;
      $display("FAIL R10: predicted count=%0d events=%0d expected count=5 events=2", m_count, m_events);
    end
    n_checks++;
    // R2: decrement from large count
    step(0, 0, 1, 0, 32'h8000_0000, "R7");
    step(1, 0, 0, 0, '0, "R2");
    step(1, 0, 0, 0, '0, "R2");
    // R8: change reload mid-run, count unaffected, used at next reload
    step(0, 0, 1, 0, 32'd2, "R7");
    step(1, 1, 0, 0, 32'd3, "R8");
    step(1, 0, 0, 0, '0, "R8");
    step(1, 0, 0, 0, '0, "R3");
    step(1, 0, 0, 0, '0, "R2");
    // R8: reload write on the reloading tick uses the old value
    step(0, 0, 1, 0, 32'd0, "R7");
    step(1, 1, 0, 0, 32'd9, "R8");
    step(1, 0, 0, 0, '0, "R2");
    // R7: load racing a tick
    step(1, 0, 1, 0, 32'd40, "R7");
    step(1, 0, 0, 0, '0, "R2");
    step(0, 0, 1, 0, 32'd0, "R7");
    step(1, 0, 0, 1, 32'd100, "R7");
    // R9: count load on a tick at zero still advances events
    step(0, 0, 1, 0, 32'd0, "R7");
    step(1, 0, 1, 0, 32'd6, "R9");
    step(1, 0, 0, 0, '0, "R2");
    // R6: wrap of the event counter
    step(0, 1, 0, 0, 32'd0, "R8");
    step(0, 0, 1, 0, 32'd0, "R7");
    step(0, 0, 0, 1, 32'hFFFF_FFFE, "R7");
    step(1, 0, 0, 0, '0, "R6");
    step(1, 0, 0, 0, '0, "R6");
    step(1, 0, 0, 0, '0, "R6");
    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    n_checks++;
    if (count_o !== '0 || events_o !== '0) begin
      n_fail++;
      $display("FAIL R1: count=%h events=%h expected count=0 events=0", count_o, events_o);
    end
    @(negedge clk); rst_n = 1'b1;
    m_reload = '0; m_count = '0; m_events = '0;
    step(1, 0, 0, 0, '0, "R1");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule